// File: doc/BRIEF.md
# Random Number Register Block

This block is a memory-mapped random number peripheral on a single-cycle 32-bit register bus. A 32-bit Galois LFSR is a stand-in for the entropy source. It fills a small word buffer at a rate set by a clock-divider exponent. Software reads the buffer one word at a time through a data register.

Five registers are decoded: control, status, data, noise-source control and health-test control. Generator configuration is applied in only one way. Software writes the configuration together with a set conditional-reset bit. It then writes that bit low. The hardware holds the bit high while an internal reset sequence flushes the buffer and reseeds the generator.

Seed faults and clock faults come in on dedicated pins. A seed fault can be cleared in two ways:
- by the hardware, signalled on a recovery pin, which leaves the sticky flag for software to clear;
- by software, through a conditional reset.

Top module: `rng_regblock`

## Requirements
- R1: After reset, the control, status, noise and health registers read 0, and a data read returns 0.
- R2: The registers sit at byte offsets 0x00 (control), 0x04 (status), 0x08 (data), 0x0C (noise) and 0x10 (health). Each generator step replaces state s with s>>1, XORed with 0x80200003 when s[0] was 1. The words read from the data register are the successive step results, starting from the seed 0x1ACEB00C.
- R3: Control bits 5 and 8..25 are configuration. They change only on a control write that also has bit 30 set. Any other control write only updates enable (bit 2) and can set lock (bit 31).
- R4: Control bit 30 reads 1 from the write that sets it. After the next control write with bit 30 low, it keeps reading 1 for COND_CYCLES (8) cycles and then reads 0. The buffer is then empty and the word sequence restarts from the seed.
- R5: With divider exponent e in control bits 19:16, the generator adds at most one word every 2^e cycles while running.
- R6: Status bit 0 (data ready) is 1 exactly when the buffer holds a word and no seed error is active. It drops when a read empties the buffer.
- R7: A data read while status bit 0 is 0 returns 0 and consumes no word.
- R8: A seed fault flushes the buffer and sets status bit 2 (current seed error) and bit 6 (seed-error flag). Generation stays halted while bit 2 is set.
- R9: A pulse on the recovery pin clears status bit 2 and resumes generation, while bit 6 stays set. A conditional reset also clears bit 2.
- R10: Writing 0 to status bit 5 or 6 clears it and writing 1 keeps it. Status bits 0..2 ignore writes.
- R11: Status bit 1 follows the clock-fault pin while control bit 5 is 1. Status bit 5 is set whenever bit 1 is 1 and stays set.
- R12: The noise register keeps only write bits 17:0 and reads 0 above them. The health register keeps all 32 bits.
- R13: Once control bit 31 is written 1, it stays 1 until hardware reset. While it is 1, configuration, noise and health writes have no effect, but the conditional-reset sequence still runs.
- R14: The buffer holds DEPTH (4) words. A full buffer stalls the generator without losing a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| seedFaultIn | input | 1 | Injected seed fault |
| seedRecoverIn | input | 1 | Injected hardware recovery from a seed fault |
| clockFaultIn | input | 1 | Injected clock fault |

## Verification
The hardest condition to reach is a state in which the configuration has been written without the conditional-reset bit, or with the lock set. There the generator keeps running on the old divider exponent, and only the spacing of the words shows this. The stimulus runs a directed sequence that exits each conditional reset at a known cycle. It then probes the ready bit just before and just after the predicted first word. After that, random reads and idle gaps check that each non-zero word follows the bench's own model of the sequence, and zero reads show that no word was skipped.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_NOISE = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_HLTH  = 5'h10;

  localparam int BIT_EN   = 2;
  localparam int BIT_CED  = 5;
  localparam int BIT_COND = 30;
  localparam int BIT_LOCK = 31;
  localparam int DIV_LO   = 16;
  localparam int DIV_HI   = 19;
  localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;
  localparam int NOISE_W  = 18;

  typedef struct packed {
    logic step;    // advance generator and push its word
    logic flush;   // empty the buffer
    logic reseed;  // restart generator from seed
    logic pop;     // consume head word
  } dpStrobe_t;
endpackage

// File: rtl/rng_datapath.sv
module rng_datapath
  import rng_pkg::*;
#(
  parameter int          DEPTH = 4,
  parameter logic [31:0] SEED  = 32'h1ACE_B00C,
  parameter logic [31:0] TAPS  = 32'h8020_0003
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobe_t  strb,
  output logic [31:0] headWord,
  output logic       notEmpty,
  output logic       full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [31:0] lfsrState, lfsrNext;
  logic [31:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic push, popOk;

  assign lfsrNext = lfsrState[0] ? ((lfsrState >> 1) ^ TAPS) : (lfsrState >> 1);
  assign push     = strb.step && !strb.flush;
  assign popOk    = strb.pop && !strb.flush;
  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headWord = slots[rdPtr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsrState <= SEED;
    else if (strb.reseed) lfsrState <= SEED;
    else if (strb.step) lfsrState <= lfsrNext;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[i] <= '0;
      else if (push && wrPtr == PTR_W'(i)) slots[i] <= lfsrNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(popOk);
    end
  end

  assert_pop_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> notEmpty);
  assert_no_overflow_R14: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |-> !full);
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> !notEmpty);
endmodule

// File: rtl/rng_control.sv
module rng_control
  import rng_pkg::*;
#(
  parameter int COND_CYCLES = 8,
  parameter int DIV_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              seedFaultIn,
  input  logic              seedRecoverIn,
  input  logic              clockFaultIn,
  input  logic [31:0]       headWord,
  input  logic              notEmpty,
  input  logic              full,
  output dpStrobe_t         strb
);
  localparam int BUSY_W = $clog2(COND_CYCLES + 1);

  logic [31:0] cfgReg;
  logic enReg, lockReg, condPend;
  logic [BUSY_W-1:0] busyCnt;
  logic [NOISE_W-1:0] noiseReg;
  logic [31:0] hlthReg;
  logic secs, seis, ceis;
  logic [DIV_W-1:0] divCnt, divMask;

  logic ctrlWr, statWr, noiseWr, hlthWr, dataRd;
  logic condBusy, condDone, running, tick, cecs, drdy;

  assign ctrlWr  = busSel && busWrite && busAddr == ADR_CTRL;
  assign statWr  = busSel && busWrite && busAddr == ADR_STAT;
  assign noiseWr = busSel && busWrite && busAddr == ADR_NOISE && !lockReg;
  assign hlthWr  = busSel && busWrite && busAddr == ADR_HLTH && !lockReg;
  assign dataRd  = busSel && !busWrite && busAddr == ADR_DATA;

  assign condBusy = condPend || (busyCnt != '0);
  assign condDone = (busyCnt == BUSY_W'(1)) && !(ctrlWr && busWdata[BIT_COND]);
  assign running  = enReg && !secs && !condBusy;
  assign divMask  = ~({DIV_W{1'b1}} << cfgReg[DIV_HI:DIV_LO]);
  assign tick     = running && (divCnt == divMask);
  assign cecs     = clockFaultIn && cfgReg[BIT_CED];
  assign drdy     = notEmpty && !secs;

  always_comb begin
    strb.step   = tick && !full;
    strb.flush  = condBusy || seedFaultIn;
    strb.reseed = condDone;
    strb.pop    = dataRd && drdy;
  end

  // control register, conditional reset sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg   <= '0;
      enReg    <= 1'b0;
      lockReg  <= 1'b0;
      condPend <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (ctrlWr) begin
        enReg   <= busWdata[BIT_EN];
        lockReg <= lockReg | busWdata[BIT_LOCK];
        if (busWdata[BIT_COND] && !lockReg) cfgReg <= busWdata & CFG_MASK;
      end
      if (ctrlWr && busWdata[BIT_COND]) begin
        condPend <= 1'b1;
        busyCnt  <= '0;
      end else if (ctrlWr && condPend) begin
        condPend <= 1'b0;
        busyCnt  <= BUSY_W'(COND_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noiseReg <= '0;
      hlthReg  <= '0;
    end else begin
      if (noiseWr) noiseReg <= busWdata[NOISE_W-1:0];
      if (hlthWr) hlthReg <= busWdata;
    end
  end

  // status flags: set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs <= 1'b0;
      seis <= 1'b0;
      ceis <= 1'b0;
    end else begin
      if (seedFaultIn) secs <= 1'b1;
      else if (seedRecoverIn || condDone) secs <= 1'b0;
      if (seedFaultIn) seis <= 1'b1;
      else if (statWr && !busWdata[6]) seis <= 1'b0;
      if (cecs) ceis <= 1'b1;
      else if (statWr && !busWdata[5]) ceis <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (!running || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_CTRL: begin
        busRdata           = cfgReg;
        busRdata[BIT_EN]   = enReg;
        busRdata[BIT_COND] = condBusy;
        busRdata[BIT_LOCK] = lockReg;
      end
      ADR_STAT:  busRdata = {25'b0, seis, ceis, 2'b0, secs, cecs, drdy};
      ADR_DATA:  busRdata = drdy ? headWord : '0;
      ADR_NOISE: busRdata = {{(32 - NOISE_W){1'b0}}, noiseReg};
      ADR_HLTH:  busRdata = hlthReg;
      default:   busRdata = '0;
    endcase
  end

  assert_lock_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    lockReg |=> lockReg);
  assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    lockReg |=> $stable(cfgReg));
  assert_seed_stops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    secs |-> !drdy);
  assert_seed_flag_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secs) |-> seis);
  assert_busy_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    condBusy |-> !strb.step);
  assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busyCnt <= BUSY_W'(COND_CYCLES));
  assert_cfg_needs_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrlWr && busWdata[BIT_COND]) |=> $stable(cfgReg));
endmodule

// File: rtl/rng_regblock.sv
module rng_regblock
  import rng_pkg::*;
#(
  parameter int          DEPTH       = 4,
  parameter int          COND_CYCLES = 8,
  parameter logic [31:0] SEED        = 32'h1ACE_B00C,
  parameter logic [31:0] TAPS        = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        seedFaultIn,
  input  logic        seedRecoverIn,
  input  logic        clockFaultIn
);
  dpStrobe_t strb;
  logic [31:0] headWord;
  logic notEmpty, full;

  rng_control #(.COND_CYCLES(COND_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .seedFaultIn(seedFaultIn), .seedRecoverIn(seedRecoverIn),
    .clockFaultIn(clockFaultIn), .headWord(headWord),
    .notEmpty(notEmpty), .full(full), .strb(strb)
  );

  rng_datapath #(.DEPTH(DEPTH), .SEED(SEED), .TAPS(TAPS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .headWord(headWord),
    .notEmpty(notEmpty), .full(full)
  );
endmodule

// File: tb/sim_rng_regblock.sv
`timescale 1ns/1ps
module sim_rng_regblock;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic seedFaultIn = 0, seedRecoverIn = 0, clockFaultIn = 0;

  int checks = 0, fails = 0;
  logic [31:0] model, v;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rng_regblock u0 (.clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .seedFaultIn(seedFaultIn), .seedRecoverIn(seedRecoverIn), .clockFaultIn(clockFaultIn));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic condReset(input logic [31:0] setVal, input logic [31:0] relVal);
    wr(5'h00, setVal);
    wr(5'h00, relVal);
    idle(10);
    model = SEED;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model = SEED;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h04, v); chk("R1 status", v, 0);
    rd(5'h0C, v); chk("R1 noise", v, 0);
    rd(5'h10, v); chk("R1 health", v, 0);
    rd(5'h08, v); chk("R7 empty data read", v, 0);

    // R12 noise width and health
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); chk("R12 noise mask", v, 32'h0003_FFFF);
    wr(5'h10, 32'h1234_ABCD); rd(5'h10, v); chk("R12 health", v, 32'h1234_ABCD);

    // R3 config without cond reset ignored, enable taken
    wr(5'h00, 32'h00F0_F0F4);
    rd(5'h00, v); chk("R3 cfg ignored", v, 32'h0000_0004);
    idle(12);
    rd(5'h04, v); chk("R6 ready when filled", v & 32'h7, 32'h1);
    // R2/R14: buffer full and stalled, read DEPTH+2 words in order
    for (int i = 0; i < DEPTH + 2; i++) begin
      rd(5'h08, v); model = nxt(model);
      chk("R2 R14 sequence", v, model);
    end

    // R4 conditional reset with exponent 3 and clock-error detect
    wr(5'h00, 32'h4003_0024);
    rd(5'h00, v); chk("R4 cond bit set", v, 32'h4003_0024);
    rd(5'h04, v); chk("R4 flushed while pending", v & 32'h1, 0);
    wr(5'h00, 32'h0000_0004);
    idle(5);
    rd(5'h00, v); chk("R4 cond held", v, 32'h4003_0024);
    idle(3);
    rd(5'h00, v); chk("R4 cond cleared", v, 32'h0003_0024);
    rd(5'h04, v); chk("R5 no word before 2^e", v & 32'h1, 0);
    idle(6);
    rd(5'h04, v); chk("R5 word after 2^e", v & 32'h1, 1);
    model = SEED;
    rd(5'h08, v); model = nxt(model); chk("R4 reseeded", v, model);
    rd(5'h04, v); chk("R6 ready drops on empty", v & 32'h1, 0);
    rd(5'h08, v); chk("R7 read when not ready", v, 0);
    idle(10);
    rd(5'h08, v); model = nxt(model); chk("R7 no word consumed", v, model);

    // R11 clock error
    clockFaultIn = 1; idle(2);
    rd(5'h04, v); chk("R11 clock flags", v & 32'h22, 32'h22);
    clockFaultIn = 0; idle(1);
    rd(5'h04, v); chk("R11 flag sticky", v & 32'h22, 32'h20);
    wr(5'h04, 32'h0000_0027);
    rd(5'h04, v); chk("R10 write 1 keeps", v & 32'h20, 32'h20);
    wr(5'h04, 32'h0000_0000);
    rd(5'h04, v); chk("R10 write 0 clears", v & 32'h20, 0);

    // R8 seed fault
    idle(12);
    seedFaultIn = 1; idle(1); seedFaultIn = 0;
    rd(5'h04, v); chk("R8 seed flags", v & 32'h45, 32'h44);
    rd(5'h08, v); chk("R8 data zero", v, 0);
    idle(20);
    wr(5'h04, 32'h0000_0000 | 32'h40);
    rd(5'h04, v); chk("R10 status low bits ignore write", v & 32'h45, 32'h44);

    // R9 hardware recovery
    seedRecoverIn = 1; idle(1); seedRecoverIn = 0;
    rd(5'h04, v); chk("R9 auto recover", v & 32'h44, 32'h40);
    idle(12);
    rd(5'h08, v); chk("R9 words resume", (v != 0) ? 32'h1 : 32'h0, 32'h1);
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R9 sw clears flag", v & 32'h40, 0);

    // R9 recovery through conditional reset
    seedFaultIn = 1; idle(1); seedFaultIn = 0;
    condReset(32'h4003_0024, 32'h0000_0004);
    rd(5'h04, v); chk("R9 cond clears seed", v & 32'h44, 32'h40);
    wr(5'h04, 32'h0);

    // R13 lock
    wr(5'h00, 32'h8000_0004);
    rd(5'h00, v); chk("R13 lock set", v, 32'h8003_0024);
    wr(5'h00, 32'h4000_0004);
    rd(5'h00, v); chk("R13 cfg frozen", v, 32'hC003_0024);
    wr(5'h00, 32'h0000_0004);
    idle(10);
    model = SEED;
    rd(5'h00, v); chk("R13 cond still runs", v, 32'h8003_0024);
    wr(5'h0C, 32'h0000_0155); rd(5'h0C, v); chk("R13 noise locked", v, 32'h0003_FFFF);
    wr(5'h10, 32'h0); rd(5'h10, v); chk("R13 health locked", v, 32'h1234_ABCD);

    // random reads and gaps against the model
    for (int i = 0; i < 80; i++) begin
      int sel;
      sel = int'($urandom % 4);
      if (sel < 2) begin
        rd(5'h08, v);
        if (v != 0) begin
          model = nxt(model);
          chk("R2 R7 random sequence", v, model);
        end
      end else if (sel == 2) begin
        idle(int'($urandom % 10));
      end else begin
        rd(5'h04, v); chk("R6 no error flags", v & 32'h66, 0);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule